// File: doc/BRIEF.md
# Logic Slice Storage Bank

This block holds the registered state of one logic slice. It has eight logic positions, each with two storage elements, sixteen in all. Positions 0 to 3 form the lower half and positions 4 to 7 form the upper half. A mode bit for each half makes every element in that half either an edge-triggered flip-flop or a level-sensitive latch. All elements share one clock. Each element reads its data from one of three per-slice sources: the lookup output of its position, a dedicated bypass input of its own, or the arithmetic/wide-multiplexer result of its position.

Four clock enables serve the bank, one for each pairing of half and slot. A single set/reset line, with a polarity inversion control, starts initialization. Each element is configured on its own to take its initial value either on the clock edge or at once, and to initialize to one or to zero. The configuration inputs are static settings that sit beside the data inputs. Element `e` sits at position `e / 2` and slot `e % 2`, and appears on output bit `q[e]`.

Top module: `sbank_top`

## Requirements
- R1: Source code `src_sel[2e+1:2e]` picks element e's data: 2'b00 and 2'b11 pick `lut_o[e/2]`, 2'b01 picks `byp[e]`, 2'b10 picks `alt[e/2]`.
- R2: In flip-flop mode, an element with initialization inactive loads its selected data on a rising clock edge when its enable is 1. It keeps its value when its enable is 0 and between edges.
- R3: Element e is gated by `ce[2*h + (e%2)]`, where h is 0 for positions 0–3 and 1 for positions 4–7.
- R4: In latch mode, an element follows its selected data while the clock is high and its enable is 1, and holds while the clock is low or its enable is 0.
- R5: `half_latch[0]` sets the mode of elements 0–7 and `half_latch[1]` sets the mode of elements 8–15 (1 = latch, 0 = flip-flop), with no effect across halves.
- R6: An element with `init_async[e]`=0 takes its initial value only on a rising edge (flip-flop) or while the clock is high (latch), whatever its enable.
- R7: An element with `init_async[e]`=1 takes its initial value as soon as initialization is active, with no clock edge, and keeps it while initialization stays active.
- R8: The initial value of element e is `init_set[e]` (1 = set, 0 = reset).
- R9: Initialization is active when `sr ^ sr_inv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; also the latch gate |
| ce | input | 4 | Clock enables, indexed by half and slot |
| sr | input | 1 | Set/reset line |
| sr_inv | input | 1 | Inverts the active level of `sr` |
| half_latch | input | 2 | Latch mode for the lower and upper halves |
| init_async | input | 16 | Per-element asynchronous initialization select |
| init_set | input | 16 | Per-element initial value |
| src_sel | input | 32 | Per-element 2-bit data source code |
| lut_o | input | 8 | Lookup output of each position |
| byp | input | 16 | Direct bypass input of each element |
| alt | input | 8 | Carry/wide-mux result of each position |
| q | output | 16 | Element outputs |

## Verification
The assertions assume that the configuration inputs and `sr` change only while the clock is low. They also assume that `init_set`, `init_async` and `sr_inv` change only in a cycle where initialization ends up inactive. Under these assumptions an asynchronous initialization never has to pick up a new value while it is already asserted. The stimulus keeps to this rule. The bench drives configuration and `sr` just after the falling edge, and starts every random segment with its new configuration and an inactive set/reset. During the high phase it changes only data and enables, which exercises latch transparency against flip-flop hold.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
   localparam int SEL_W  = 2;
   localparam int HALVES = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_LUT    = 2'd0,
      SRC_DIRECT = 2'd1,
      SRC_ALT    = 2'd2,
      SRC_SPARE  = 2'd3
   } src_e;
endpackage

// File: rtl/sbank_srcmux.sv
module sbank_srcmux
   import sbank_pkg::*;
(
   input  logic [SEL_W-1:0] sel,
   input  logic             lut_bit,
   input  logic             byp_bit,
   input  logic             alt_bit,
   output logic             d
);
   always_comb begin
      case (src_e'(sel))
         SRC_DIRECT: d = byp_bit;
         SRC_ALT:    d = alt_bit;
         default:    d = lut_bit;
      endcase
   end
endmodule

// File: rtl/sbank_cell.sv
module sbank_cell (
   input  logic clk,
   input  logic ce,
   input  logic d,
   input  logic sr_act,
   input  logic is_async,
   input  logic init_val,
   input  logic latch_mode,
   output logic q
);
   logic q_ff;
   logic q_lat;
   logic async_hit;

   assign async_hit = sr_act & is_async;

   always_ff @(posedge clk or posedge async_hit) begin
      if (async_hit)   q_ff <= init_val;
      else if (sr_act) q_ff <= init_val;
      else if (ce)     q_ff <= d;
   end

   always_latch begin
      if (async_hit) q_lat <= init_val;
      else if (clk) begin
         if (sr_act)  q_lat <= init_val;
         else if (ce) q_lat <= d;
      end
   end

   assign q = latch_mode ? q_lat : q_ff;

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   a_r2_capture: assert property (@(posedge clk) disable iff (!armed)
      (!sr_act && ce) |=> ((q_ff == $past(d)) || sr_act));

   a_r2_hold: assert property (@(posedge clk) disable iff (!armed)
      (!sr_act && !ce) |=> ($stable(q_ff) || sr_act));

   a_r6_sync_init: assert property (@(posedge clk) disable iff (!armed)
      (sr_act && !is_async) |=> ((q_ff == $past(init_val)) || sr_act));

   a_r7_async_init: assert property (@(posedge clk) disable iff (!armed)
      (sr_act && is_async) |=> (q_ff == $past(init_val)));

   a_r4_latch_follow: assert property (@(negedge clk) disable iff (!armed)
      (!sr_act && ce) |-> (q_lat == d));
endmodule

// File: rtl/sbank_half.sv
module sbank_half
   import sbank_pkg::*;
#(
   parameter int HALF_POS = 4,
   parameter int PER_POS  = 2
) (
   input  logic                          clk,
   input  logic [PER_POS-1:0]            ce,
   input  logic                          sr_act,
   input  logic                          latch_mode,
   input  logic [HALF_POS*PER_POS-1:0]   init_async,
   input  logic [HALF_POS*PER_POS-1:0]   init_set,
   input  logic [HALF_POS*PER_POS*SEL_W-1:0] src_sel,
   input  logic [HALF_POS-1:0]           lut_o,
   input  logic [HALF_POS*PER_POS-1:0]   byp,
   input  logic [HALF_POS-1:0]           alt,
   output logic [HALF_POS*PER_POS-1:0]   q
);
   localparam int HE = HALF_POS * PER_POS;

   logic [HE-1:0] d_w;

   for (genvar j = 0; j < HALF_POS; j++) begin : g_pos
      for (genvar k = 0; k < PER_POS; k++) begin : g_slot
         localparam int E = j * PER_POS + k;

         sbank_srcmux u_mux (
            .sel     (src_sel[E*SEL_W +: SEL_W]),
            .lut_bit (lut_o[j]),
            .byp_bit (byp[E]),
            .alt_bit (alt[j]),
            .d       (d_w[E])
         );

         sbank_cell u_cell (
            .clk        (clk),
            .ce         (ce[k]),
            .d          (d_w[E]),
            .sr_act     (sr_act),
            .is_async   (init_async[E]),
            .init_val   (init_set[E]),
            .latch_mode (latch_mode),
            .q          (q[E])
         );
      end
   end
endmodule

// File: rtl/sbank_top.sv
module sbank_top
   import sbank_pkg::*;
#(
   parameter int POSITIONS = 8,
   parameter int PER_POS   = 2
) (
   input  logic                                  clk,
   input  logic [HALVES*PER_POS-1:0]             ce,
   input  logic                                  sr,
   input  logic                                  sr_inv,
   input  logic [HALVES-1:0]                     half_latch,
   input  logic [POSITIONS*PER_POS-1:0]          init_async,
   input  logic [POSITIONS*PER_POS-1:0]          init_set,
   input  logic [POSITIONS*PER_POS*SEL_W-1:0]    src_sel,
   input  logic [POSITIONS-1:0]                  lut_o,
   input  logic [POSITIONS*PER_POS-1:0]          byp,
   input  logic [POSITIONS-1:0]                  alt,
   output logic [POSITIONS*PER_POS-1:0]          q
);
   localparam int HALF_POS = POSITIONS / HALVES;
   localparam int HE       = HALF_POS * PER_POS;

   if (POSITIONS < HALVES || (POSITIONS % HALVES) != 0) begin : g_bad_pos
      $error("sbank_top: POSITIONS must be a positive even count");
   end
   if (PER_POS < 1) begin : g_bad_slot
      $error("sbank_top: PER_POS must be at least one");
   end

   logic sr_act;
   assign sr_act = sr ^ sr_inv;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      sbank_half #(
         .HALF_POS (HALF_POS),
         .PER_POS  (PER_POS)
      ) u_half (
         .clk        (clk),
         .ce         (ce[h*PER_POS +: PER_POS]),
         .sr_act     (sr_act),
         .latch_mode (half_latch[h]),
         .init_async (init_async[h*HE +: HE]),
         .init_set   (init_set[h*HE +: HE]),
         .src_sel    (src_sel[h*HE*SEL_W +: HE*SEL_W]),
         .lut_o      (lut_o[h*HALF_POS +: HALF_POS]),
         .byp        (byp[h*HE +: HE]),
         .alt        (alt[h*HALF_POS +: HALF_POS]),
         .q          (q[h*HE +: HE])
      );
   end
endmodule

// File: tb/sim_sbank_top.sv
module sim_sbank_top;
   logic        clk = 1'b0;
   logic [3:0]  ce = '0;
   logic        sr = 1'b0;
   logic        sr_inv = 1'b0;
   logic [1:0]  half_latch = '0;
   logic [15:0] init_async = '0;
   logic [15:0] init_set = '0;
   logic [31:0] src_sel = '0;
   logic [7:0]  lut_o = '0;
   logic [15:0] byp = '0;
   logic [7:0]  alt = '0;
   logic [15:0] q;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] m_ff = '0;
   logic [15:0] m_lat = '0;

   sbank_top u0 (.clk(clk), .ce(ce), .sr(sr), .sr_inv(sr_inv), .half_latch(half_latch),
      .init_async(init_async), .init_set(init_set), .src_sel(src_sel),
      .lut_o(lut_o), .byp(byp), .alt(alt), .q(q));

   always #4 clk = ~clk;

   function automatic logic dval(int e);
      logic [1:0] c = src_sel[2*e +: 2];
      if (c == 2'd1) return byp[e];
      if (c == 2'd2) return alt[e/2];
      return lut_o[e/2];
   endfunction

   function automatic int cidx(int e);
      return (((e/2) >= 4) ? 2 : 0) + (e % 2);
   endfunction

   function automatic logic act();
      return sr ^ sr_inv;
   endfunction

   function automatic logic [15:0] expq();
      logic [15:0] r;
      for (int e = 0; e < 16; e++) r[e] = half_latch[e/8] ? m_lat[e] : m_ff[e];
      return r;
   endfunction

   task automatic settle(input logic high);
      for (int e = 0; e < 16; e++) begin
         if (act() && init_async[e]) begin
            m_ff[e]  = init_set[e];
            m_lat[e] = init_set[e];
         end else if (high) begin
            if (act())            m_lat[e] = init_set[e];
            else if (ce[cidx(e)]) m_lat[e] = dval(e);
         end
      end
   endtask

   task automatic edge_upd();
      for (int e = 0; e < 16; e++) begin
         if (act())            m_ff[e] = init_set[e];
         else if (ce[cidx(e)]) m_ff[e] = dval(e);
      end
      settle(1'b1);
   endtask

   task automatic check(input string tag);
      logic [15:0] x = expq();
      n_cmp++;
      if (q !== x) begin
         n_bad++;
         $display("FAIL %s: q=%h expected %h at %0t", tag, q, x, $time);
      end
   endtask

   // caller sets phase-A inputs while clk is low; phase B is applied in the high phase
   task automatic go(input string tpre, input string tpost, input string tmid,
                     input logic [3:0] bce, input logic [7:0] blut,
                     input logic [15:0] bbyp, input logic [7:0] balt);
      settle(1'b0);
      #1 check(tpre);
      @(posedge clk);
      edge_upd();
      #1 check(tpost);
      #1;
      ce = bce; lut_o = blut; byp = bbyp; alt = balt;
      settle(1'b1);
      #1 check(tmid);
      @(negedge clk);
      #1;
   endtask

   task automatic go_same(input string t);
      go(t, t, t, ce, lut_o, byp, alt);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: run still going, expected it to finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0B4C));
      // reset state: async set/reset of every element
      sr = 1; sr_inv = 0; init_async = 16'hFFFF; init_set = 16'hA5C3;
      go("R7", "R8", "R8", 4'h0, 8'hFF, 16'hFFFF, 8'hFF);
      sr = 0;
      go_same("R2");
      // R9: inverted polarity, sr low means active
      sr_inv = 1; sr = 0;
      go_same("R9");
      sr = 1; ce = 4'hF; lut_o = 8'hFF;
      go_same("R9");
      // R1: every source code, then a random mix
      sr = 0; sr_inv = 0; init_async = 0; init_set = 0;
      lut_o = 8'h5A; byp = 16'h3C96; alt = 8'hC3; ce = 4'hF;
      for (int c = 0; c < 4; c++) begin
         src_sel = {16{c[1:0]}};
         go("R2", "R1", "R2", ce, ~lut_o, ~byp, ~alt);
         lut_o = ~lut_o; byp = ~byp; alt = ~alt;
         lut_o = 8'h5A; byp = 16'h3C96; alt = 8'hC3;
      end
      for (int i = 0; i < 4; i++) begin
         src_sel = $urandom; lut_o = $urandom; byp = $urandom; alt = $urandom;
         go("R1", "R1", "R1", ce, lut_o, byp, alt);
      end
      // R2: hold with enables low
      ce = 0; lut_o = ~lut_o; byp = ~byp; alt = ~alt;
      go_same("R2");
      // R3: one enable at a time
      src_sel = {16{2'b01}}; ce = 4'hF; byp = 16'h0000;
      go_same("R3");
      for (int c = 0; c < 4; c++) begin
         ce = 4'(1 << c); byp = 16'hFFFF;
         go("R3", "R3", "R3", 4'h0, lut_o, 16'h0000, alt);
      end
      // R6: synchronous initialization, priority over the enables
      ce = 4'hF; byp = 0;
      go_same("R2");
      sr = 1; init_set = 16'hFFFF; ce = 0;
      go_same("R6");
      init_set = 16'h3C3C; ce = 4'hF; byp = 16'hFFFF;
      go_same("R6");
      // R7: asynchronous initialization without an edge
      sr = 0; byp = 0;
      go_same("R2");
      init_async = 16'hFFFF; init_set = 16'hF00F;
      go_same("R2");
      sr = 1; ce = 0;
      go("R7", "R7", "R7", 4'hF, lut_o, 16'h5555, alt);
      sr = 0; ce = 0;
      go_same("R7");
      // R4: latches in both halves
      init_async = 0; half_latch = 2'b11; ce = 4'hF; byp = 16'h1234;
      go("R4", "R4", "R4", 4'hF, lut_o, 16'hABCD, alt);
      ce = 0; byp = 16'h9999;
      go("R4", "R4", "R4", 4'h0, lut_o, 16'h5555, alt);
      ce = 4'hF; byp = 16'h0F0F;
      go("R4", "R4", "R4", 4'h5, lut_o, 16'hF0F0, alt);
      // R5: one half latch, other half flop
      half_latch = 2'b01; byp = 16'h00FF;
      go("R5", "R5", "R5", 4'hF, lut_o, 16'hFF00, alt);
      half_latch = 2'b10; byp = 16'h3333;
      go("R5", "R5", "R5", 4'hF, lut_o, 16'hCCCC, alt);
      // random segments, configuration changed only with initialization inactive
      for (int s = 0; s < 40; s++) begin
         half_latch = $urandom; init_async = $urandom; init_set = $urandom;
         sr_inv = $urandom; src_sel = $urandom; sr = sr_inv;
         for (int i = 0; i < 8; i++) begin
            if (i != 0) sr = (($urandom % 4) == 0) ? ~sr_inv : sr_inv;
            ce = $urandom; lut_o = $urandom; byp = $urandom; alt = $urandom;
            go("R5", "R5", "R5", 4'($urandom), 8'($urandom), 16'($urandom), 8'($urandom));
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule